// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept by the receiver. It watches the received byte stream, collects the six destination address bytes, and classifies the address as broadcast, multicast or unicast. The class is then weighed against four acceptance modes and a receiver enable: promiscuous, multicast, broadcast, and a unicast mode that compares the address with a programmed station address.

The station address is held in two 32-bit host registers with a byte-reversed lane layout. The block also maps those lanes onto the address. A frame begins with a start strobe, and a separate valid strobe qualifies each byte. The verdict is registered. It is shown with a one-cycle done strobe and then held until the next frame starts. Frame reception, CRC handling and buffering belong to other blocks.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `done` and `accept` are 0 and both station register read ports return 0.
- R2: The low station register reads back all 32 written bits. The high station register reads back bits 15..0 as written and bits 31..16 as zero.
- R3: Byte 0 is the first destination byte on the wire and byte 5 the last. The station address takes byte 0 from high-register bits 7..0 and byte 1 from high-register bits 15..8. It takes bytes 2, 3, 4 and 5 from low-register bits 7..0, 15..8, 23..16 and 31..24.
- R4: With the receiver enabled and promiscuous mode set, every frame is accepted.
- R5: A broadcast address has all 48 bits set to one. With the receiver enabled and broadcast mode set, it is accepted. With broadcast mode clear it is rejected, unless promiscuous mode accepts it.
- R6: A multicast address has bit 0 of byte 0 set and is not broadcast. With the receiver enabled and multicast mode set, it is accepted. With multicast mode clear it is rejected, unless promiscuous mode or a unicast station match accepts it.
- R7: With the receiver enabled and unicast mode set, a frame whose six destination bytes equal the station address is accepted. An address that differs in any byte is not accepted by this mode.
- R8: While the receiver enable is 0, no frame is accepted.
- R9: `done` is high for exactly one cycle, in the clock after the sixth valid destination byte is sampled. `accept` shows the verdict in that same cycle. Cycles with `byte_vld` low are not counted as bytes.
- R10: A start-of-frame strobe clears `accept` and `done` in the next cycle. If `byte_vld` is high in the start cycle, that byte is taken as byte 0 of the new frame.
- R11: Bytes after the sixth cause no further `done` pulse and leave `accept` unchanged until the next start-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame strobe |
| byte_vld | input | 1 | Qualifies `byte_in` |
| byte_in | input | 8 | Received byte |
| rx_en | input | 1 | Receiver enable |
| promisc_en | input | 1 | Accept all frames |
| mcast_en | input | 1 | Accept multicast frames |
| bcast_en | input | 1 | Accept broadcast frames |
| ucast_en | input | 1 | Accept frames matching the station address |
| sta_lo_we | input | 1 | Write strobe for the low station register |
| sta_hi_we | input | 1 | Write strobe for the high station register |
| sta_wdata | input | 32 | Station register write data |
| sta_lo_rd | output | 32 | Low station register contents |
| sta_hi_rd | output | 32 | High station register contents, upper half zero |
| done | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
Two events can land in the same cycle. A start-of-frame can coincide with the capture of the first destination byte. A start-of-frame can also arrive in the very cycle that `done` is showing the previous verdict. The bench alternates the start strobe between a separate cycle and the cycle of byte 0. It also fires the next start either at once while `done` is high or after trailing bytes. It then checks that the new frame's verdict is computed from the right six bytes and that the old verdict is gone one cycle after the strobe. Every mode combination is swept against broadcast, multicast, near-broadcast, exact-match and single-byte-miss addresses for two station addresses.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam int OCT_W     = 8;
  localparam int MAC_BYTES = 6;
  localparam int MAC_W     = OCT_W * MAC_BYTES;
  localparam int REG_W     = 32;
  localparam int HI_USED   = 2 * OCT_W;
  localparam int CNT_W     = $clog2(MAC_BYTES + 1);

  typedef logic [MAC_W-1:0] mac_t;

  typedef enum logic [1:0] {
    CLS_UNI   = 2'd0,
    CLS_MULTI = 2'd1,
    CLS_BCAST = 2'd2
  } cls_e;

  typedef struct packed {
    logic rx_on;
    logic promisc;
    logic multi;
    logic bcast;
    logic uni;
  } modes_t;

  // wire byte 0 sits at the top of mac_t; low register lanes are reversed
  function automatic mac_t station_from_regs(input logic [REG_W-1:0] lo,
                                             input logic [HI_USED-1:0] hi);
    mac_t m;
    for (int k = 0; k < 4; k++) begin
      m[k*OCT_W +: OCT_W] = lo[REG_W-OCT_W-k*OCT_W +: OCT_W];
    end
    m[MAC_W-1 -: OCT_W]       = hi[OCT_W-1:0];
    m[MAC_W-OCT_W-1 -: OCT_W] = hi[HI_USED-1:OCT_W];
    return m;
  endfunction

  function automatic cls_e classify(input mac_t d);
    if (&d)                 return CLS_BCAST;
    else if (d[MAC_W-OCT_W]) return CLS_MULTI;
    else                    return CLS_UNI;
  endfunction

  function automatic logic accept_rule(input modes_t md, input cls_e c,
                                       input logic hit);
    logic any;
    any = md.promisc
        | (md.bcast & (c == CLS_BCAST))
        | (md.multi & (c == CLS_MULTI))
        | (md.uni & hit);
    return md.rx_on & any;
  endfunction
endpackage

// File: rtl/station_addr_regs.sv
module station_addr_regs
  import rx_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] lo_q,
  output logic [REG_W-1:0] hi_q,
  output mac_t             station
);
  logic [REG_W-1:0]   lo_r;
  logic [HI_USED-1:0] hi_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_r <= '0;
      hi_r <= '0;
    end else begin
      if (lo_we) lo_r <= wdata;
      if (hi_we) hi_r <= wdata[HI_USED-1:0];
    end
  end

  assign lo_q    = lo_r;
  assign hi_q    = {{(REG_W-HI_USED){1'b0}}, hi_r};
  assign station = station_from_regs(lo_r, hi_r);
endmodule

// File: rtl/dest_capture.sv
module dest_capture
  import rx_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             byte_vld,
  input  logic [OCT_W-1:0] byte_in,
  output mac_t             dest_now,
  output logic             last_byte
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MAC_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAC_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;
  mac_t             dest_q;
  logic             take;

  assign take      = byte_vld & (sof | (cnt_q < CNT_FULL));
  assign last_byte = byte_vld & ~sof & (cnt_q == CNT_LAST);
  assign dest_now  = {dest_q[MAC_W-OCT_W-1:0], byte_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= CNT_FULL;
      dest_q <= '0;
    end else if (sof) begin
      dest_q <= byte_vld ? {{(MAC_W-OCT_W){1'b0}}, byte_in} : '0;
      cnt_q  <= byte_vld ? CNT_W'(1) : '0;
    end else if (take) begin
      dest_q <= dest_now;
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mode_decider.sv
module mode_decider
  import rx_filt_pkg::*;
(
  input  mac_t   dest,
  input  mac_t   station,
  input  modes_t modes,
  output cls_e   cls,
  output logic   hit,
  output logic   verdict
);
  assign cls     = classify(dest);
  assign hit     = (dest == station);
  assign verdict = accept_rule(modes, cls, hit);
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rx_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  input  logic             rx_en,
  input  logic             promisc_en,
  input  logic             mcast_en,
  input  logic             bcast_en,
  input  logic             ucast_en,
  input  logic             sta_lo_we,
  input  logic             sta_hi_we,
  input  logic [31:0]      sta_wdata,
  output logic [31:0]      sta_lo_rd,
  output logic [31:0]      sta_hi_rd,
  output logic             done,
  output logic             accept
);
  mac_t   station;
  mac_t   dest_now;
  logic   last_byte;
  cls_e   frame_cls;
  logic   station_hit;
  logic   verdict;
  modes_t modes;
  logic   done_q;
  logic   accept_q;

  assign modes = '{rx_on: rx_en, promisc: promisc_en, multi: mcast_en,
                   bcast: bcast_en, uni: ucast_en};

  station_addr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .lo_we(sta_lo_we), .hi_we(sta_hi_we),
    .wdata(sta_wdata), .lo_q(sta_lo_rd), .hi_q(sta_hi_rd), .station(station)
  );

  dest_capture u_cap (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
    .byte_in(byte_in), .dest_now(dest_now), .last_byte(last_byte)
  );

  mode_decider u_dec (
    .dest(dest_now), .station(station), .modes(modes),
    .cls(frame_cls), .hit(station_hit), .verdict(verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      done_q <= last_byte;
      if (last_byte)  accept_q <= verdict;
      else if (sof)   accept_q <= 1'b0;
    end
  end

  assign done   = done_q;
  assign accept = accept_q;
endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk
  import rx_filt_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic sof,
  input logic last_byte,
  input logic rx_en,
  input logic promisc_en,
  input logic mcast_en,
  input logic bcast_en,
  input logic ucast_en,
  input cls_e frame_cls,
  input logic station_hit,
  input logic done,
  input logic accept
);
  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> done); // R9
  AST_DONE_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    !last_byte |=> !done); // R9
  AST_RX_OFF_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && !rx_en |=> !accept); // R8
  AST_PROMISC_TAKES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && rx_en && promisc_en |=> accept); // R4
  AST_BCAST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && rx_en && bcast_en && frame_cls == CLS_BCAST |=> accept); // R5
  AST_MULTI_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && !promisc_en && !mcast_en && frame_cls == CLS_MULTI
      && !(ucast_en && station_hit) |=> !accept); // R6
  AST_UNI_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && rx_en && ucast_en && station_hit |=> accept); // R7
  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !accept && !done); // R10
  AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !last_byte && !sof |=> $stable(accept)); // R11
endmodule

bind rx_dest_filter rx_dest_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .last_byte(last_byte),
  .rx_en(rx_en), .promisc_en(promisc_en), .mcast_en(mcast_en),
  .bcast_en(bcast_en), .ucast_en(ucast_en), .frame_cls(frame_cls),
  .station_hit(station_hit), .done(done), .accept(accept)
);

// File: tb/rx_dest_filter_bench.sv
`timescale 1ns/1ps
module rx_dest_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, byte_vld = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic        rx_en = 1'b0, promisc_en = 1'b0, mcast_en = 1'b0;
  logic        bcast_en = 1'b0, ucast_en = 1'b0;
  logic        sta_lo_we = 1'b0, sta_hi_we = 1'b0;
  logic [31:0] sta_wdata = 32'h0;
  logic [31:0] sta_lo_rd, sta_hi_rd;
  logic        done, accept;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  logic [47:0] sta;

  always #2.5 clk = ~clk;

  rx_dest_filter u_rx_dest_filter (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
    .byte_in(byte_in), .rx_en(rx_en), .promisc_en(promisc_en),
    .mcast_en(mcast_en), .bcast_en(bcast_en), .ucast_en(ucast_en),
    .sta_lo_we(sta_lo_we), .sta_hi_we(sta_hi_we), .sta_wdata(sta_wdata),
    .sta_lo_rd(sta_lo_rd), .sta_hi_rd(sta_hi_rd), .done(done), .accept(accept)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wire_byte(input logic [47:0] a, input int k);
    return a[47-8*k -: 8];
  endfunction

  // own model of the verdict, from the requirements
  function automatic logic model(input logic [47:0] d, input logic [4:0] md);
    logic is_b, is_m, is_h;
    is_b = 1'b1;
    is_h = 1'b1;
    for (int k = 0; k < 6; k++) begin
      if (wire_byte(d, k) != 8'hFF) is_b = 1'b0;
      if (wire_byte(d, k) != wire_byte(sta, k)) is_h = 1'b0;
    end
    is_m = wire_byte(d, 0)[0] && !is_b;
    return md[4] && (md[3] || (md[1] && is_b) || (md[2] && is_m) || (md[0] && is_h));
  endfunction

  task automatic program_station(input logic [47:0] s);
    sta = s;
    @(negedge clk);
    sta_lo_we = 1'b1;
    sta_wdata = {wire_byte(s, 5), wire_byte(s, 4), wire_byte(s, 3), wire_byte(s, 2)};
    @(negedge clk);
    sta_lo_we = 1'b0;
    sta_hi_we = 1'b1;
    sta_wdata = {16'hBEEF, wire_byte(s, 1), wire_byte(s, 0)};
    @(negedge clk);
    sta_hi_we = 1'b0;
  endtask

  // style[0]: sof with byte 0; style[1]: idle gaps; style[2]: trailing bytes
  task automatic send_frame(input logic [47:0] d, input logic [4:0] md,
                            input int style);
    logic exp;
    exp = model(d, md);
    {rx_en, promisc_en, mcast_en, bcast_en, ucast_en} = md;
    if (!style[0]) begin
      @(negedge clk);
      sof = 1'b1; byte_vld = 1'b0;
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k == 5) check("R9 no early done", {31'h0, done}, 32'h0);
      sof      = (k == 0) && style[0];
      byte_vld = 1'b1;
      byte_in  = wire_byte(d, k);
      if (style[1] && k < 5) begin
        @(negedge clk);
        sof = 1'b0; byte_vld = 1'b0; byte_in = 8'hA5;
      end
    end
    @(negedge clk);
    sof = 1'b0; byte_vld = 1'b0;
    check("R9 done after sixth byte", {31'h0, done}, 32'h1);
    check($sformatf("R4/R5/R6/R7/R8 verdict modes=%b dest=%h", md, d),
          {31'h0, accept}, {31'h0, exp});
    if (style[2]) begin
      for (int j = 0; j < 2; j++) begin
        @(negedge clk);
        byte_vld = 1'b1; byte_in = ~byte_in;
      end
      @(negedge clk);
      byte_vld = 1'b0;
      check("R11 no second done", {31'h0, done}, 32'h0);
      check("R11 verdict held", {31'h0, accept}, {31'h0, exp});
      @(negedge clk);
    end
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    check("R10 sof clears verdict", {30'h0, accept, done}, 32'h0);
  endtask

  function automatic logic [47:0] pick_dest(input int i);
    logic [47:0] a;
    case (i)
      0:  a = 48'hFFFF_FFFF_FFFF;
      1:  a = 48'h0100_5E12_3456;
      2:  a = sta;
      9:  a = 48'hFFFF_FFFF_FFFE;
      10: a = 48'h0011_2233_4455;
      default: begin
        a = sta;
        a[47-8*(i-3) -: 8] = a[47-8*(i-3) -: 8] ^ 8'h80;
      end
    endcase
    return a;
  endfunction

  initial begin
    int style;
    sta = 48'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done at reset", {31'h0, done}, 32'h0);
    check("R1 accept at reset", {31'h0, accept}, 32'h0);
    check("R1 low reg at reset", sta_lo_rd, 32'h0);
    check("R1 high reg at reset", sta_hi_rd, 32'h0);

    sta_lo_we = 1'b1; sta_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    sta_lo_we = 1'b0; sta_hi_we = 1'b1; sta_wdata = 32'hFFFF_1234;
    @(negedge clk);
    sta_hi_we = 1'b0;
    check("R2 low reg readback", sta_lo_rd, 32'hDEAD_BEEF);
    check("R2 high reg readback", sta_hi_rd, 32'h0000_1234);

    style = 0;
    foreach (sta[i]) begin end
    for (int s = 0; s < 2; s++) begin
      // R3: station built from registers in wire byte order
      program_station(s == 0 ? 48'h021A_3C5E_7091 : 48'hC0FE_E812_AB34);
      for (int a = 0; a < 11; a++) begin
        for (int m = 0; m < 32; m++) begin
          send_frame(pick_dest(a), 5'(m), style % 8);
          style++;
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule